// File: doc/BRIEF.md
# Manchester Line Encoder with Polarity, Hold and Raw Pass-Through

This block turns a serial NRZ bit stream, delivered by a controller as data plus a bit clock, into a Manchester-coded line signal for a transmit burst. The controller's bit clock and data come in from another clock domain. The block synchronises both into the system clock and captures one bit on each rising edge of the bit clock. It then plays that bit out as two half-bit symbols. The half-bit timing comes from a single-cycle tick, `half_tick`, that arrives at twice the bit rate.

A polarity input flips the encoded stream so that modulators with either local-oscillator sense can be used. A hold input stops new bits from starting. A raw mode skips the encoder and sends the synchronised serial data straight to the line. A transmit-enable input gates everything: while it is low the line rests at the idle level.

Top module: `manch_tx_enc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `line_out` is at the idle level 0 and no bit is pending.
- R2: With `pol_n` high, a bit is sent as two half-bit symbols. The first half carries the complement of the bit and the second half carries the bit. A 1 is therefore sent as 0 then 1, and a 0 as 1 then 0.
- R3: With `pol_n` low, both half-bit symbols are inverted, so a 1 is sent as 1 then 0. The idle level stays 0 whatever the polarity.
- R4: `ser_data` is captured on each rising edge of `ser_clk`, after both signals pass a synchroniser of `SYNC_STAGES` flops. One pending bit is held. A later capture made before that bit starts replaces it.
- R5: A new bit starts only on a bit boundary: a tick while idle, or the tick that ends a second half. If a bit is pending at the boundary, bits follow each other with no gap. If no bit is pending, the line goes idle.
- R6: `hold` is sampled only at bit boundaries. A bit already in flight finishes both halves. While held the line stays idle, and the pending bit is kept and sent at the first boundary after release.
- R7: While `tx_en` is low, `line_out` is 0 one cycle later. The bit in flight and any pending bit are discarded, and bits captured meanwhile are discarded too.
- R8: With `tx_en` and `bypass` both high, `line_out` follows the synchronised `ser_data` with no polarity inversion. The encoder stays idle and captured bits are discarded.
- R9: In encoding mode, with `tx_en`, `bypass` and `pol_n` steady, `line_out` changes only in the clock cycle that follows a `half_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle enable at twice the bit rate |
| tx_en | input | 1 | Transmit enable; low forces the idle level |
| ser_clk | input | 1 | Controller bit clock (asynchronous) |
| ser_data | input | 1 | Controller serial data (asynchronous) |
| hold | input | 1 | High holds off new bits at the next boundary |
| pol_n | input | 1 | Low inverts the encoded stream |
| bypass | input | 1 | High sends raw synchronised data to the line |
| line_out | output | 1 | Encoded line bit, registered |

## Verification
The assertions check four things on every cycle. The line is idle during and just after reset, and whenever transmit is disabled. In raw mode the line equals the serial input delayed by the synchroniser depth plus one. In encoding mode the line moves only right after a half-bit tick.

The actual symbol values need the bench's scenarios. These cover the half-bit order for each bit value under both polarities, and back-to-back bits without gaps. They also cover the replacement of a pending bit and completion of an in-flight bit under hold. Finally they cover the release of a held bit, and the discarding of bits across disable and raw mode.

// File: rtl/manch_tx_enc.sv
module manch_tx_enc #(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic tx_en,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic hold,
  input  logic pol_n,
  input  logic bypass,
  output logic line_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clk_sync, dat_sync;
  logic clk_prev;
  logic pend_vld, pend_bit;
  logic busy, second_half, cur_bit;

  wire clk_s    = clk_sync[TOP];
  wire dat_s    = dat_sync[TOP];
  wire capture  = clk_s & ~clk_prev;
  wire flush    = ~tx_en | bypass;
  wire boundary = half_tick & (~busy | second_half);
  wire start    = boundary & pend_vld & ~hold & ~flush;

  wire enc_half  = second_half ? cur_bit : ~cur_bit;
  wire enc_line  = busy ? (enc_half ^ ~pol_n) : IDLE_LEVEL;
  wire next_line = ~tx_en ? IDLE_LEVEL : (bypass ? dat_s : enc_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= '0;
      dat_sync <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[TOP-1:0], ser_clk};
      dat_sync <= {dat_sync[TOP-1:0], ser_data};
      clk_prev <= clk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_bit <= 1'b0;
    end else if (flush) begin
      pend_vld <= 1'b0;
    end else if (capture) begin
      pend_vld <= 1'b1;
      pend_bit <= dat_s;
    end else if (start) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      second_half <= 1'b0;
      cur_bit     <= 1'b0;
    end else if (flush) begin
      busy        <= 1'b0;
      second_half <= 1'b0;
    end else if (boundary) begin
      busy        <= start;
      second_half <= 1'b0;
      if (start) cur_bit <= pend_bit;
    end else if (half_tick) begin
      second_half <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_out <= IDLE_LEVEL;
    else     line_out <= next_line;
  end

endmodule

// File: rtl/manch_tx_enc_chk.sv
module manch_tx_enc_chk #(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic half_tick,
  input logic tx_en,
  input logic ser_data,
  input logic pol_n,
  input logic bypass,
  input logic line_out
);

  localparam int LAT = SYNC_STAGES + 1;

  logic [LAT-1:0] dly;
  int unsigned age;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly <= '0;
      age <= 0;
    end else begin
      dly <= {dly[LAT-2:0], ser_data};
      if (age < LAT + 2) age <= age + 1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> line_out == IDLE_LEVEL);

  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 1 && !$past(tx_en)) |-> line_out == IDLE_LEVEL);

  assert_raw_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (age >= LAT && $past(tx_en) && $past(bypass)) |-> line_out == dly[LAT-1]);

  assert_tick_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (age >= 3 && !$past(half_tick, 2) && $past(tx_en) && $past(tx_en, 2) &&
     !$past(bypass) && !$past(bypass, 2) && $past(pol_n) == $past(pol_n, 2))
    |-> $stable(line_out));

endmodule

bind manch_tx_enc manch_tx_enc_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .half_tick(half_tick),
  .tx_en    (tx_en),
  .ser_data (ser_data),
  .pol_n    (pol_n),
  .bypass   (bypass),
  .line_out (line_out)
);

// File: tb/tb_manch_tx_enc.sv
module tb_manch_tx_enc;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0, tx_en = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
  logic hold = 1'b0, pol_n = 1'b1, bypass = 1'b0;
  logic line_out;

  int checks = 0, errors = 0;
  bit steady = 1'b1;
  bit done = 1'b0;
  logic  exp_q[$];
  string tag_q[$];
  event  smp;

  always #4 clk = ~clk;

  manch_tx_enc dut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .tx_en(tx_en),
    .ser_clk(ser_clk), .ser_data(ser_data), .hold(hold),
    .pol_n(pol_n), .bypass(bypass), .line_out(line_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: line_out actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic enc(logic b, bit second, logic pn);
    return (second ? b : ~b) ^ ~pn;
  endfunction

  // monitor: pops one expected item per half-bit slot
  initial forever begin
    @(smp);
    if (exp_q.size() == 0) begin
      chk(line_out, 1'bx, "scoreboard-empty");
    end else begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(line_out, e, t);
    end
  end

  // one half-bit slot of 8 cycles; optional new bit fed mid-slot
  task automatic slot(input logic e, input string tag, input bit feed, input logic b);
    logic seen;
    @(negedge clk); half_tick = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); half_tick = 1'b0;
    @(negedge clk);
    @(negedge clk); -> smp; seen = line_out;
    if (feed) begin ser_data = b; ser_clk = 1'b1; end
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    ser_clk = 1'b0;
    if (steady) chk(line_out, seen, "R9 mid-slot stability");
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] w, input int n, input string tag);
    slot(1'b0, "R5 idle before burst", 1'b1, w[n-1]);
    for (int i = n - 1; i >= 0; i--) begin
      slot(enc(w[i], 1'b0, pol_n), tag, 1'b0, 1'b0);
      slot(enc(w[i], 1'b1, pol_n), tag, i > 0, (i > 0) ? w[i-1] : 1'b0);
    end
    slot(1'b0, "R5 idle after burst", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(line_out, 1'b0, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk(line_out, 1'b0, "R1 after reset");
    tx_en = 1'b1;
    slot(1'b0, "R5 idle nothing pending", 1'b0, 1'b0);
    slot(1'b0, "R5 idle nothing pending", 1'b0, 1'b0);

    // R2 normal polarity, back-to-back bits
    send_bits(8'b10110, 5, "R2 encode normal");

    // R3 inverted polarity
    pol_n = 1'b0;
    send_bits(8'b1001, 4, "R3 encode inverted");
    slot(1'b0, "R3 idle unaffected", 1'b0, 1'b0);
    pol_n = 1'b1;

    // R4 + R6: two captures under hold, newest survives and is kept
    hold = 1'b1;
    slot(1'b0, "R6 held idle", 1'b1, 1'b0);
    slot(1'b0, "R6 held idle", 1'b1, 1'b1);
    slot(1'b0, "R6 held idle", 1'b0, 1'b0);
    hold = 1'b0;
    slot(enc(1'b1, 1'b0, 1'b1), "R4 newest capture", 1'b0, 1'b0);
    slot(enc(1'b1, 1'b1, 1'b1), "R4 newest capture", 1'b0, 1'b0);
    slot(1'b0, "R5 idle", 1'b0, 1'b0);

    // R6 hold mid-bit: in-flight bit completes
    slot(1'b0, "R5 idle", 1'b1, 1'b1);
    slot(enc(1'b1, 1'b0, 1'b1), "R2 first half", 1'b0, 1'b0);
    hold = 1'b1;
    slot(enc(1'b1, 1'b1, 1'b1), "R6 in-flight completes", 1'b1, 1'b0);
    slot(1'b0, "R6 held", 1'b0, 1'b0);
    slot(1'b0, "R6 held", 1'b0, 1'b0);
    hold = 1'b0;
    slot(enc(1'b0, 1'b0, 1'b1), "R6 released bit", 1'b0, 1'b0);
    slot(enc(1'b0, 1'b1, 1'b1), "R6 released bit", 1'b0, 1'b0);
    slot(1'b0, "R5 idle", 1'b0, 1'b0);

    // R7 disable mid-bit drops in-flight and pending bits
    slot(1'b0, "R5 idle", 1'b1, 1'b1);
    slot(enc(1'b1, 1'b0, 1'b1), "R2 first half", 1'b1, 1'b0);
    tx_en = 1'b0;
    slot(1'b0, "R7 disabled forces idle", 1'b1, 1'b1);
    tx_en = 1'b1;
    slot(1'b0, "R7 pending dropped", 1'b0, 1'b0);
    slot(1'b0, "R7 pending dropped", 1'b0, 1'b0);

    // R8 raw mode, no inversion
    steady = 1'b0;
    pol_n = 1'b0;
    ser_data = 1'b0;
    bypass = 1'b1;
    slot(1'b0, "R8 raw data", 1'b1, 1'b1);
    slot(1'b1, "R8 raw data", 1'b1, 1'b0);
    slot(1'b0, "R8 raw data", 1'b1, 1'b1);
    slot(1'b1, "R8 raw data", 1'b0, 1'b0);
    tx_en = 1'b0;
    slot(1'b0, "R7 raw gated by enable", 1'b0, 1'b0);
    tx_en = 1'b1;
    slot(1'b1, "R8 raw data", 1'b1, 1'b1);
    bypass = 1'b0;
    steady = 1'b1;
    slot(1'b0, "R8 raw captures discarded", 1'b0, 1'b0);
    slot(1'b0, "R8 raw captures discarded", 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk(1'b1, 1'b0, "scoreboard-leftover");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule